// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block monitors sixteen digital input pins and raises a single interrupt line when a configured change-of-state condition occurs on them. Software sets the condition through a small 32-bit register bus with separate read and write strobes. Two channel masks select which inputs take part and with which polarity. A control register enables interrupt generation and picks one of two combination modes. In edge mode, any enabled channel that sees its selected transition raises the interrupt. In level mode, the interrupt fires only when every enabled channel is at its selected level at the same time.

Each pin passes through a two-flop synchroniser before any detection. When an event fires, a status register records the channels that caused it, and the interrupt line stays high until software reads that register. In level mode the detector blocks itself after firing. A fresh level change on one of the selected inputs must occur before it can fire again. Software can briefly hide the interrupt by clearing the enable bit and then writing the old control value back. The masks are kept while the interrupt is hidden.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, irq_o is low and reads of the raw (0x00), high/rise mask (0x04), low/fall mask (0x08), status (0x0C) and control (0x10) registers all return zero, given that the pins are low.
- R2: A read of offset 0x00 returns the synchronised pin value in bits 15:0. A pin change first appears there two clock edges after it is driven. Writes to 0x00 have no effect.
- R3: In edge mode (control = 0b01: bit 0 enable, bit 1 mode with 0 = edge), a rising edge on a channel whose bit is set in the 0x04 mask raises irq_o, and the status register then holds that channel's bit.
- R4: In edge mode, a falling edge on a channel set in the 0x08 mask raises irq_o. A channel set in both masks fires on either edge. Edges on channels not set in the relevant mask raise nothing.
- R5: In level mode (control = 0b11), irq_o rises only when every channel set in the 0x04 mask is high and every channel set in the 0x08 mask is low. Status then holds the union of both masks.
- R6: After a level-mode event, the detector stays blocked while the inputs are unchanged, and changes on unselected pins do not unblock it. It fires again only after a level change on a selected input and a return to the full condition.
- R7: A read of the status register returns its value and clears it. If no new event fires in that cycle, irq_o drops on the same clock edge.
- R8: Once raised, irq_o stays high on every following cycle until the status register is read.
- R9: With control bit 0 clear, no new events are recorded and a pending interrupt is hidden from irq_o. Writing the previous control value back shows the pending interrupt again, and the masks are kept.
- R10: The masks hold 16 bits and the control register holds 2 bits; upper write data is discarded. Reads of unmapped offsets return zero.
- R11: irq_o rises on the third rising clock edge after a qualifying pin change is driven: two edges in the synchroniser and one to register the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | 16 | Asynchronous digital inputs |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe; a status read clears the status register at the clock edge |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt request, high while an event is pending and enabled |

## Verification
The in-RTL assertions check several rules on every cycle. A fired event always sets the pending flag, and a pending flag always comes with a non-zero status. A status read with no new event clears both. An edge-mode event never fires without a pin change, and a level-mode event never fires on two cycles in a row. The bench scenarios cover the rest. A sweep over all sixteen channels checks the polarity of each mask and that unmasked channels are ignored. Sequences in level mode check the all-channels condition and the blocking after each event. The bench also checks the exact cycle on which the interrupt rises, and that the configuration survives when the interrupt is hidden and shown again.

// File: rtl/cos_pkg.sv
`timescale 1ns/1ps
package cos_pkg;
    localparam int ADDR_W = 5;
    localparam logic [ADDR_W-1:0] OFS_RAW  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_HI   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_LO   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h10;

    typedef struct packed {
        logic level_mode;  // bit 1: 0 = edge/any, 1 = level/all
        logic enable;      // bit 0
    } ctrl_t;
endpackage

// File: rtl/cos_sync.sv
`timescale 1ns/1ps
module cos_sync #(
    parameter int N = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] pins_i,
    output logic [N-1:0] sync_o,
    output logic [N-1:0] prev_o
);
    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] sync;
        logic [N-1:0] prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pins_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_o = st_q.sync;
    assign prev_o = st_q.prev;
endmodule

// File: rtl/cos_detect.sv
`timescale 1ns/1ps
module cos_detect #(
    parameter int N = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,
    input  logic         level_mode_i,
    input  logic [N-1:0] hi_mask_i,
    input  logic [N-1:0] lo_mask_i,
    input  logic [N-1:0] sync_i,
    input  logic [N-1:0] prev_i,
    output logic         fire_o,
    output logic [N-1:0] hit_o
);
    typedef struct packed {
        logic armed;
    } st_t;

    st_t st_d, st_q;

    logic [N-1:0] rise, fall, edge_hit, sel, cond;
    logic         all_met, sel_change, edge_fire, level_fire;

    always_comb begin
        rise       = sync_i & ~prev_i;
        fall       = ~sync_i & prev_i;
        edge_hit   = (rise & hi_mask_i) | (fall & lo_mask_i);
        sel        = hi_mask_i | lo_mask_i;
        cond       = (hi_mask_i & sync_i) | (lo_mask_i & ~sync_i) | ~sel;
        all_met    = (sel != '0) && (&cond);
        sel_change = |((sync_i ^ prev_i) & sel);
        edge_fire  = en_i && !level_mode_i && (edge_hit != '0);
        level_fire = en_i && level_mode_i && st_q.armed && all_met;

        st_d = st_q;
        if (level_fire)      st_d.armed = 1'b0;
        else if (sel_change) st_d.armed = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{armed: 1'b1};
        else         st_q <= st_d;
    end

    assign fire_o = edge_fire | level_fire;
    assign hit_o  = level_mode_i ? sel : edge_hit;

    // R6: a level event blocks itself for at least the next cycle
    a_r6_level_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_fire |=> !level_fire);
    // R4: an edge-mode event needs a pin change
    a_r4_edge_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_fire |-> (sync_i != prev_i));
endmodule

// File: rtl/cos_regs.sv
`timescale 1ns/1ps
module cos_regs
    import cos_pkg::*;
#(
    parameter int N  = 16,
    parameter int DW = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [N-1:0]      sync_i,
    input  logic              fire_i,
    input  logic [N-1:0]      hit_i,
    output logic [N-1:0]      hi_mask_o,
    output logic [N-1:0]      lo_mask_o,
    output ctrl_t             ctrl_o,
    output logic [DW-1:0]     rdata_o,
    output logic              irq_o
);
    localparam int PAD = DW - N;
    localparam int CW  = $bits(ctrl_t);

    typedef struct packed {
        logic [N-1:0] hi_mask;
        logic [N-1:0] lo_mask;
        logic [N-1:0] status;
        ctrl_t        ctrl;
        logic         pend;
    } st_t;

    st_t  st_d, st_q;
    logic rd_stat;
    logic unused_wdata;

    assign unused_wdata = ^wdata_i[DW-1:N];
    assign rd_stat      = rd_i && (addr_i == OFS_STAT);

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            unique case (addr_i)
                OFS_HI:   st_d.hi_mask = wdata_i[N-1:0];
                OFS_LO:   st_d.lo_mask = wdata_i[N-1:0];
                OFS_CTRL: st_d.ctrl    = ctrl_t'(wdata_i[CW-1:0]);
                default:  ;
            endcase
        end
        if (rd_stat) begin
            st_d.status = '0;
            st_d.pend   = 1'b0;
        end
        if (fire_i) begin
            st_d.status = (rd_stat ? '0 : st_q.status) | hit_i;
            st_d.pend   = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            OFS_RAW:  rdata_o = {{PAD{1'b0}}, sync_i};
            OFS_HI:   rdata_o = {{PAD{1'b0}}, st_q.hi_mask};
            OFS_LO:   rdata_o = {{PAD{1'b0}}, st_q.lo_mask};
            OFS_STAT: rdata_o = {{PAD{1'b0}}, st_q.status};
            OFS_CTRL: rdata_o = {{(DW-CW){1'b0}}, st_q.ctrl};
            default:  rdata_o = '0;
        endcase
    end

    assign hi_mask_o = st_q.hi_mask;
    assign lo_mask_o = st_q.lo_mask;
    assign ctrl_o    = st_q.ctrl;
    assign irq_o     = st_q.pend & st_q.ctrl.enable;

    // R8: an event always leaves a pending interrupt behind
    a_r8_fire_sets_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_i |=> st_q.pend);
    // R7: a status read with no new event clears status and pending
    a_r7_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_stat && !fire_i) |=> (!st_q.pend && st_q.status == '0));
    // R3: a pending interrupt always names at least one channel
    a_r3_pending_has_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pend |-> (st_q.status != '0));
endmodule

// File: rtl/cos_irq_ctrl.sv
`timescale 1ns/1ps
module cos_irq_ctrl
    import cos_pkg::*;
#(
    parameter int N  = 16,
    parameter int DW = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N-1:0]      pins_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DW-1:0]     bus_wdata_i,
    output logic [DW-1:0]     bus_rdata_o,
    output logic              irq_o
);
    logic [N-1:0] sync, prev, hi_mask, lo_mask, hit;
    logic         fire;
    ctrl_t        ctrl;

    cos_sync #(.N(N)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pins_i (pins_i),
        .sync_o (sync),
        .prev_o (prev)
    );

    cos_detect #(.N(N)) u_detect (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .en_i         (ctrl.enable),
        .level_mode_i (ctrl.level_mode),
        .hi_mask_i    (hi_mask),
        .lo_mask_i    (lo_mask),
        .sync_i       (sync),
        .prev_i       (prev),
        .fire_o       (fire),
        .hit_o        (hit)
    );

    cos_regs #(.N(N), .DW(DW)) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (bus_wr_i),
        .rd_i      (bus_rd_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .sync_i    (sync),
        .fire_i    (fire),
        .hit_i     (hit),
        .hi_mask_o (hi_mask),
        .lo_mask_o (lo_mask),
        .ctrl_o    (ctrl),
        .rdata_o   (bus_rdata_o),
        .irq_o     (irq_o)
    );
endmodule

// File: tb/cos_irq_ctrl_tb.sv
`timescale 1ns/1ps
module cos_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pins = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          errors = 0, checks = 0;
    logic [31:0] v;

    always #4 clk = ~clk;

    cos_irq_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .pins_i(pins),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr_reg(logic [4:0] a, logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(logic [4:0] a, output logic [31:0] d);
        rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        for (int a = 0; a <= 16; a += 4) begin
            rd_reg(a[4:0], v); chk("R1 reg", v, 32'h0);
        end

        // R10 widths and unmapped
        wr_reg(5'h04, 32'hFFFF_1234); rd_reg(5'h04, v); chk("R10 hi mask", v, 32'h1234);
        wr_reg(5'h08, 32'hABCD_8765); rd_reg(5'h08, v); chk("R10 lo mask", v, 32'h8765);
        wr_reg(5'h10, 32'hFFFF_FFFC); rd_reg(5'h10, v); chk("R10 ctrl", v, 32'h0);
        rd_reg(5'h14, v); chk("R10 unmapped", v, 32'h0);
        wr_reg(5'h04, 0); wr_reg(5'h08, 0);

        // R2 raw input latency and ignored write
        pins = 16'hA5C3;
        @(negedge clk);
        rd_reg(5'h00, v); chk("R2 raw after one edge", v, 32'h0);
        rd_reg(5'h00, v); chk("R2 raw after two edges", v, 32'hA5C3);
        wr_reg(5'h00, 32'hFFFF); rd_reg(5'h00, v); chk("R2 write ignored", v, 32'hA5C3);
        pins = '0; settle();

        // R11 timing of the interrupt
        wr_reg(5'h04, 32'h1); wr_reg(5'h10, 32'h1);
        pins = 16'h1;
        repeat (2) @(negedge clk); chk("R11 low after two edges", {31'b0, irq}, 0);
        @(negedge clk);            chk("R11 high after three edges", {31'b0, irq}, 1);
        // R8 held
        repeat (10) @(negedge clk); chk("R8 irq held", {31'b0, irq}, 1);
        rd_reg(5'h0C, v); chk("R7 status value", v, 32'h1);
        chk("R7 irq dropped", {31'b0, irq}, 0);
        rd_reg(5'h0C, v); chk("R7 status cleared", v, 32'h0);
        pins = '0; settle();

        // R3/R4 sweep over every channel in edge mode
        for (int ch = 0; ch < 16; ch++) begin
            logic [15:0] b, o;
            b = 16'(1) << ch;
            o = 16'(1) << (ch ^ 1);
            wr_reg(5'h04, {16'b0, b}); wr_reg(5'h08, 0);
            pins = o; settle(); chk("R4 unmasked rise", {31'b0, irq}, 0);
            pins = 0; settle(); chk("R4 unmasked fall", {31'b0, irq}, 0);
            pins = b; settle(); chk("R3 rise fires", {31'b0, irq}, 1);
            rd_reg(5'h0C, v); chk("R3 status bit", v, {16'b0, b});
            chk("R7 irq cleared", {31'b0, irq}, 0);
            pins = 0; settle(); chk("R4 fall ignored by hi mask", {31'b0, irq}, 0);
            wr_reg(5'h04, 0); wr_reg(5'h08, {16'b0, b});
            pins = b; settle(); chk("R4 rise ignored by lo mask", {31'b0, irq}, 0);
            pins = 0; settle(); chk("R4 fall fires", {31'b0, irq}, 1);
            rd_reg(5'h0C, v); chk("R4 status bit", v, {16'b0, b});
        end

        // R4 both masks: either edge
        wr_reg(5'h04, 32'h8); wr_reg(5'h08, 32'h8);
        pins = 16'h8; settle(); chk("R4 both rise", {31'b0, irq}, 1);
        rd_reg(5'h0C, v); chk("R4 both rise status", v, 32'h8);
        pins = 0; settle(); chk("R4 both fall", {31'b0, irq}, 1);
        rd_reg(5'h0C, v); chk("R4 both fall status", v, 32'h8);

        // R9 hide and restore
        wr_reg(5'h04, 32'h10); wr_reg(5'h08, 0);
        pins = 16'h10; settle(); chk("R9 pending", {31'b0, irq}, 1);
        wr_reg(5'h10, 0); chk("R9 hidden", {31'b0, irq}, 0);
        wr_reg(5'h10, 1); chk("R9 restored", {31'b0, irq}, 1);
        rd_reg(5'h04, v); chk("R9 mask kept", v, 32'h10);
        rd_reg(5'h0C, v); chk("R9 status", v, 32'h10);
        pins = 0; settle();
        wr_reg(5'h10, 0);
        pins = 16'h10; settle();
        wr_reg(5'h10, 1); settle();
        chk("R9 no event while disabled", {31'b0, irq}, 0);
        rd_reg(5'h0C, v); chk("R9 status empty", v, 32'h0);
        pins = 0; settle();

        // R5 level mode
        wr_reg(5'h04, 32'h3); wr_reg(5'h08, 32'h4); wr_reg(5'h10, 32'h3);
        settle(); chk("R5 none met", {31'b0, irq}, 0);
        pins = 16'h1; settle(); chk("R5 partial", {31'b0, irq}, 0);
        pins = 16'h7; settle(); chk("R5 low not met", {31'b0, irq}, 0);
        pins = 16'h3; settle(); chk("R5 all met", {31'b0, irq}, 1);
        rd_reg(5'h0C, v); chk("R5 status union", v, 32'h7);

        // R6 blocked until selected change
        settle(); chk("R6 blocked steady", {31'b0, irq}, 0);
        pins = 16'h23; settle(); chk("R6 unselected change", {31'b0, irq}, 0);
        pins = 16'h22; settle(); chk("R6 broken", {31'b0, irq}, 0);
        pins = 16'h23; settle(); chk("R6 refire", {31'b0, irq}, 1);
        rd_reg(5'h0C, v); chk("R6 status", v, 32'h7);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule